// File: doc/BRIEF.md
# Four-Queue Write Port with Shareable Full Flag

This block is the input side of a multi-queue FIFO. It holds four queues, and each entry is 36 bits wide. The write address bus carries two parts. The upper bits name a device in a chain of up to eight devices, and the low bits name one of that device's queues. The address is taken on a rising write-clock edge only while the address-enable input is high. If the device field matches this device's strapped identity, the named queue becomes the active queue from the next cycle on. Each rising edge with the active-low write enable asserted then pushes the data bus into the active queue.

The block reports one active-low full flag, and it always describes the active queue. The flag comes with an output enable, so that the flags of several devices can be joined on one line. Only the device that owns the current selection enables its flag. Every other device releases the line and holds its own flag value high. A small read port (queue select, pop strobe, head data, empty) is included so that queue contents can be observed.

Top module: `mq_write_port`

## Requirements
- R1: After a clock edge with `rst_n` low, all four queues are empty, `full_oe` is 0 and `full_n` is 1.
- R2: A selection is captured at a rising edge where `wr_addr_en` is 1. Bits [4:2] of `wr_addr` are compared with `dev_id`, and bits [1:0] name the queue. `full_oe` and `full_n` reflect the new selection in the cycle after that edge. A write in the same cycle as the selection still goes to the previously active queue.
- R3: At a rising edge where this device holds the selection and `wr_en_n` is 0, `wr_data` is appended to the active queue, provided that queue is not full.
- R4: While `full_oe` is 1, `full_n` is 0 exactly when the active queue holds DEPTH words (16 by default), and 1 otherwise.
- R5: A write into a full queue is ignored. The queue keeps its DEPTH words, and they read back in their original order.
- R6: When the last captured selection named a different device, `full_oe` is 0, `full_n` is 1, and writes do not change any queue.
- R7: A rising edge with `wr_en_n` at 1 writes nothing.
- R8: `rd_data` and `rd_empty` show the head of queue `rd_q` in the same cycle. A rising edge with `rd_en` at 1 removes the head from a non-empty queue, so entries come out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_id | input | 3 | This device's position in the flag chain |
| wr_addr | input | 5 | Device field [4:2] and queue field [1:0] |
| wr_addr_en | input | 1 | Qualifies `wr_addr` as a new selection |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 36 | Word to be written |
| full_n | output | 1 | Active-low full status of the active queue |
| full_oe | output | 1 | High when this device should drive the shared flag line |
| rd_q | input | 2 | Queue observed by the read port |
| rd_en | input | 1 | Pops the head of queue `rd_q` |
| rd_data | output | 36 | Head word of queue `rd_q` |
| rd_empty | output | 1 | Queue `rd_q` holds no words |

## Verification
A selection or a write that is presented at one rising edge shows its effect in the following cycle. The flag and its enable change right after that edge, and a pushed word shows as the read-port head at the same point. The bench therefore changes inputs on falling edges and checks results at the next falling edge, after the one rising edge that counts. Read data and empty are combinational from queue state, so they are checked shortly after `rd_q` changes and before the pop edge. Writes that should be ignored are checked at the ports: the queue is drained afterwards and must return exactly the words expected and then report empty.

// File: rtl/mq_pkg.sv
// Package: shared sizing defaults and types for the multi-queue write port.
// Assumes queue count and depth are powers of two.
package mq_pkg;
    localparam int MQ_NUM_Q  = 4;
    localparam int MQ_DATA_W = 36;
    localparam int MQ_DEPTH  = 16;
    localparam int MQ_ID_W   = 3;
    localparam int MQ_QSEL_W = $clog2(MQ_NUM_Q);
    localparam int MQ_ADDR_W = MQ_ID_W + MQ_QSEL_W;

    typedef logic [MQ_QSEL_W-1:0] qsel_t;
endpackage

// File: rtl/mq_queue_sel.sv
// mq_queue_sel: captures the active-queue selection from the write address.
// Assumes the device field is the upper ID_W bits and the queue field the
// low QSEL_W bits of wr_addr. A selection is taken only when wr_addr_en is high.
module mq_queue_sel #(
    parameter int ID_W   = 3,
    parameter int QSEL_W = 2,
    localparam int ADDR_W = ID_W + QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_addr_en,
    output logic              sel_hit,
    output logic [QSEL_W-1:0] sel_q
);
    logic id_match;

    // Compare the device field of the address with the strapped identity.
    always_comb begin
        id_match = (wr_addr[ADDR_W-1:QSEL_W] == dev_id);
    end

    // Hold the last qualified selection until the next one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hit <= 1'b0;
            sel_q   <= '0;
        end else if (wr_addr_en) begin
            sel_hit <= id_match;
            sel_q   <= wr_addr[QSEL_W-1:0];
        end
    end
endmodule

// File: rtl/mq_queue_bank.sv
// mq_queue_bank: one circular queue with push/pop strobes.
// Assumes DEPTH is a power of two so the pointers wrap naturally. A push
// while full and a pop while empty are dropped without moving any pointer.
module mq_queue_bank #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push;
    logic              do_pop;

    // Derive status and qualify the strobes against it.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and occupancy for accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R5: a full queue stays full unless something is popped.
    p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    // R8: an empty queue stays empty unless something is pushed.
    p_empty_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

// File: rtl/mq_flag_drive.sv
// mq_flag_drive: forms the shared full flag and its output enable.
// Assumes an external pull-up on the shared line, so a device that is not
// driving also presents its own flag value as inactive (high).
module mq_flag_drive #(
    parameter int NUM_Q  = 4,
    parameter int QSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_hit,
    input  logic [QSEL_W-1:0] sel_q,
    input  logic [NUM_Q-1:0]  q_full,
    output logic              full_n,
    output logic              full_oe
);
    // Report the active queue's status only while this device owns the line.
    always_comb begin
        full_oe = sel_hit;
        full_n  = !(sel_hit && q_full[sel_q]);
    end

    // R6: a released line always reads as not full.
    p_released_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_oe |-> full_n);
endmodule

// File: rtl/mq_write_port.sv
// mq_write_port: four-queue write port with a shareable active-low full flag.
// Assumes one clock domain for writing and for the observation read port.
module mq_write_port #(
    parameter int NUM_Q  = mq_pkg::MQ_NUM_Q,
    parameter int DATA_W = mq_pkg::MQ_DATA_W,
    parameter int DEPTH  = mq_pkg::MQ_DEPTH,
    parameter int ID_W   = mq_pkg::MQ_ID_W,
    localparam int QSEL_W = $clog2(NUM_Q),
    localparam int ADDR_W = ID_W + QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_addr_en,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              full_oe,
    input  logic [QSEL_W-1:0] rd_q,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    logic              sel_hit;
    logic [QSEL_W-1:0] sel_q;
    logic [NUM_Q-1:0]  q_push;
    logic [NUM_Q-1:0]  q_pop;
    logic [NUM_Q-1:0]  q_full;
    logic [NUM_Q-1:0]  q_empty;
    logic [DATA_W-1:0] q_dout [NUM_Q];

    mq_queue_sel #(.ID_W(ID_W), .QSEL_W(QSEL_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_id     (dev_id),
        .wr_addr    (wr_addr),
        .wr_addr_en (wr_addr_en),
        .sel_hit    (sel_hit),
        .sel_q      (sel_q)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        // Steer write and read strobes to this queue.
        always_comb begin
            q_push[g] = sel_hit && !wr_en_n && (sel_q == QSEL_W'(g));
            q_pop[g]  = rd_en && (rd_q == QSEL_W'(g));
        end

        mq_queue_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .din   (wr_data),
            .pop   (q_pop[g]),
            .dout  (q_dout[g]),
            .full  (q_full[g]),
            .empty (q_empty[g])
        );
    end

    // Present the observed queue's head on the read port.
    always_comb begin
        rd_data  = q_dout[rd_q];
        rd_empty = q_empty[rd_q];
    end

    mq_flag_drive #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_hit (sel_hit),
        .sel_q   (sel_q),
        .q_full  (q_full),
        .full_n  (full_n),
        .full_oe (full_oe)
    );

    // R2: a matching selection takes the flag line in the next cycle.
    p_sel_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr_en && (wr_addr[ADDR_W-1:QSEL_W] == dev_id)) |=> full_oe);

    // R6: a selection for another device releases the flag line.
    p_sel_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr_en && (wr_addr[ADDR_W-1:QSEL_W] != dev_id)) |=> !full_oe);

    // R2: without a new selection the line ownership does not change.
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr_en |=> $stable(full_oe));
endmodule

// File: tb/mq_write_port_tb.sv
// Directed bench for mq_write_port: one task per scenario, each self-checking.
module mq_write_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  dev_id = 3'd5;
    logic [4:0]  wr_addr = '0;
    logic        wr_addr_en = 1'b0;
    logic        wr_en_n = 1'b1;
    logic [35:0] wr_data = '0;
    logic        full_n;
    logic        full_oe;
    logic [1:0]  rd_q = '0;
    logic        rd_en = 1'b0;
    logic [35:0] rd_data;
    logic        rd_empty;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    mq_write_port u_dut (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .wr_addr(wr_addr),
        .wr_addr_en(wr_addr_en), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .full_n(full_n), .full_oe(full_oe), .rd_q(rd_q), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act,
                         input logic [35:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_select(input logic [2:0] id, input logic [1:0] q);
        wr_addr = {id, q};
        wr_addr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_addr_en = 1'b0;
    endtask

    task automatic do_write(input logic [35:0] d);
        wr_data = d;
        wr_en_n = 1'b0;
        @(posedge clk); @(negedge clk);
        wr_en_n = 1'b1;
    endtask

    task automatic read_expect(input logic [1:0] q, input logic [35:0] exp, input string req);
        rd_q = q;
        #1;
        check(rd_empty == 1'b0, req, 36'(rd_empty), 36'd0);
        check(rd_data == exp, req, rd_data, exp);
        rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input logic [1:0] q, input string req);
        rd_q = q;
        #1;
        check(rd_empty == 1'b1, req, 36'(rd_empty), 36'd1);
    endtask

    // R1: reset state.
    task automatic t_reset();
        check(full_oe == 1'b0, "R1", 36'(full_oe), 36'd0);
        check(full_n == 1'b1, "R1", 36'(full_n), 36'd1);
        for (int q = 0; q < 4; q++) expect_empty(2'(q), "R1");
    endtask

    // R6: a selection for device 2 releases the line and blocks writes.
    task automatic t_other_device();
        do_select(3'd2, 2'd1);
        check(full_oe == 1'b0, "R6", 36'(full_oe), 36'd0);
        check(full_n == 1'b1, "R6", 36'(full_n), 36'd1);
        do_write(36'h123456789);
        for (int q = 0; q < 4; q++) expect_empty(2'(q), "R6");
    endtask

    // R2, R3, R8, R7: matching selection, in-order writes, idle enable.
    task automatic t_basic_write();
        do_select(3'd5, 2'd1);
        check(full_oe == 1'b1, "R2", 36'(full_oe), 36'd1);
        check(full_n == 1'b1, "R2", 36'(full_n), 36'd1);
        for (int i = 0; i < 3; i++) do_write(36'hA0000_0000 + 36'(i));
        wr_data = 36'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) read_expect(2'd1, 36'hA0000_0000 + 36'(i), "R3");
        expect_empty(2'd1, "R7");
    endtask

    // R4, R5, R2: fill queue 2, overfill, switch away and back, drain.
    task automatic t_fill();
        do_select(3'd5, 2'd2);
        for (int i = 0; i < 15; i++) do_write(36'h200 + 36'(i));
        check(full_n == 1'b1, "R4", 36'(full_n), 36'd1);
        do_write(36'h200 + 36'd15);
        check(full_n == 1'b0, "R4", 36'(full_n), 36'd0);
        do_write(36'hBAD_BAD);
        check(full_n == 1'b0, "R5", 36'(full_n), 36'd0);
        do_select(3'd5, 2'd0);
        check(full_n == 1'b1, "R2", 36'(full_n), 36'd1);
        do_select(3'd5, 2'd2);
        check(full_n == 1'b0, "R2", 36'(full_n), 36'd0);
        read_expect(2'd2, 36'h200, "R5");
        check(full_n == 1'b1, "R4", 36'(full_n), 36'd1);
        for (int i = 1; i < 16; i++) read_expect(2'd2, 36'h200 + 36'(i), "R5");
        expect_empty(2'd2, "R5");
    endtask

    // R2: a write in the selection cycle goes to the previously active queue.
    task automatic t_same_cycle();
        do_select(3'd5, 2'd0);
        wr_addr = {3'd5, 2'd3};
        wr_addr_en = 1'b1;
        wr_data = 36'hC0FFEE;
        wr_en_n = 1'b0;
        @(posedge clk); @(negedge clk);
        wr_addr_en = 1'b0;
        wr_en_n = 1'b1;
        expect_empty(2'd3, "R2");
        read_expect(2'd0, 36'hC0FFEE, "R2");
    endtask

    // R6: losing the selection to another device releases the line.
    task automatic t_release();
        do_select(3'd5, 2'd1);
        check(full_oe == 1'b1, "R6", 36'(full_oe), 36'd1);
        do_select(3'd7, 2'd1);
        check(full_oe == 1'b0, "R6", 36'(full_oe), 36'd0);
        check(full_n == 1'b1, "R6", 36'(full_n), 36'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_other_device();
        t_basic_write();
        t_fill();
        t_same_cycle();
        t_release();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule